// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block sits between an on-chip read bus and a serial flash device. A read issued to the memory window is not answered from local storage. It is expanded into a complete flash read: chip select falls, a read opcode goes out, then the window-relative address, then a programmable number of idle (dummy) clocks. After that, 32 data bits are captured and the word is handed back to the requester.

A 32-bit setup value fully describes the flash sequence. It holds the opcode, the number of address bytes, the dummy byte and bit counts, and whether data arrives on one line or on four. The setup value is sampled once, when a read is accepted. A mode-enable input decides whether window reads are serviced at all; when it is low, the serial port is left to a separate register-driven engine. The serial clock runs at half the system clock in mode 0: it idles low, and the flash samples on the rising edge.

Top module: `flash_mmap_reader`

## Requirements
- R1: While reset is held low and after it is released, `fl_cs_n` is 1, `fl_sclk` is 0 and `bus_ready` is 0 until a read is accepted.
- R2: While `mm_en` is 0, a pending `bus_req` does not lower `fl_cs_n` and never raises `bus_ready`.
- R3: The first 8 serial clocks of an access carry `setup[7:0]` on `fl_mosi`, most significant bit first. Each bit is valid while `fl_sclk` is high.
- R4: `setup[9:8]` = v sends v+1 address bytes after the opcode, most significant first. They are the low bytes of `bus_addr - WIN_BASE`, so v = 2 gives a 3-byte address.
- R5: The address is followed by 8*`setup[11:10]` + `setup[28:24]` dummy clocks, during which `fl_mosi` is 0.
- R6: If `setup[13:12]` = 3, data takes 8 clocks, and each clock captures `fl_io_in[3:0]` as a nibble with bit 3 most significant. The first nibble lands in bits 31:28. For any other value, data takes 32 clocks on `fl_io_in[1]`, and the first bit lands in bit 31.
- R7: `bus_ready` stays 0 until all data clocks are done, then is 1 for exactly one cycle with the word on `bus_rdata`. `fl_cs_n` is already 1 in that cycle.
- R8: Between two accesses, `fl_cs_n` stays 1 for at least two system cycles (one serial clock period).
- R9: The setup value is sampled when a read is accepted. Changing `setup` during an access has no effect on that access. `setup[23:16]` (the write opcode) has no effect on reads.
- R10: `fl_sclk` is 0 whenever `fl_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mm_en | input | 1 | Memory-mapped mode enable |
| setup | input | 32 | Read-sequence setup value |
| bus_req | input | 1 | Read request, held until `bus_ready` |
| bus_addr | input | AW | Read address inside the window |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sclk | output | 1 | Serial clock |
| fl_mosi | output | 1 | Serial command/address line |
| fl_io_in | input | 4 | Flash data lines (bit 1 in single mode) |

## Verification
The assertions take for granted that a requester holds `bus_req` and `bus_addr` steady until it sees `bus_ready`, and that `mm_en` only changes while no access is in flight. The stimulus honours both rules. It lowers the request on the same falling edge on which the strobe is seen. It toggles the enable only before accesses start. The flash model drives its data lines while the serial clock is low, so they are stable through the rising edge where they are sampled. The one deliberate breach of a steady input is `setup`, which is changed mid-access to show that it is ignored.

// File: rtl/fls_pkg.sv
// Package: shared types and sequence-length helpers for the flash read translator.
// Assumes the setup word layout described in the brief (fields at fixed bit positions).
package fls_pkg;

    typedef struct packed {
        logic [2:0] rsv_hi;      // 31:29 unused
        logic [4:0] dum_bits;    // 28:24 extra dummy clocks
        logic [7:0] wr_op;       // 23:16 write opcode, not used for reads
        logic [1:0] rsv_mid;     // 15:14 unused
        logic [1:0] rd_kind;     // 13:12 data capture type
        logic [1:0] dum_bytes;   // 11:10 dummy bytes
        logic [1:0] addr_bytes;  // 9:8   address bytes minus one
        logic [7:0] rd_op;       // 7:0   read opcode
    } setup_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_DUMMY,
        ST_DATA,
        ST_ACK
    } seq_st_t;

    localparam logic [1:0] RD_QUAD = 2'd3;
    localparam int         CNT_W   = 7;

    // Serial clocks for opcode plus address: 8 + 8*(ab+1).
    function automatic logic [CNT_W-1:0] send_clocks(input logic [1:0] ab);
        return {2'b00, ab, 3'b000} + 7'd16;
    endfunction

    // Dummy clocks: 8 per dummy byte plus the extra bit count.
    function automatic logic [CNT_W-1:0] dummy_clocks(input logic [1:0] db, input logic [4:0] dbits);
        return {2'b00, db, 3'b000} + {2'b00, dbits};
    endfunction

endpackage

// File: rtl/fls_seq_ctrl.sv
// Sequencer: accepts a window read, latches the setup fields, walks the
// send / dummy / data phases one serial clock (two system cycles) per bit,
// and strobes ready once the word is complete.
// Assumes bus_req and the address stay stable until ready.
module fls_seq_ctrl
    import fls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mm_en,
    input  logic       bus_req,
    input  setup_t     setup_i,
    output logic [7:0] op_o,
    output logic [1:0] ab_o,
    output logic       quad_o,
    output logic       load_o,
    output logic       shift_o,
    output logic       cap_o,
    output logic       cs_n_o,
    output logic       sclk_o,
    output logic       ready_o
);

    seq_st_t          state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ph_q;
    logic             cs_n_q;
    logic [7:0]       op_q;
    logic [1:0]       ab_q;
    logic [1:0]       db_q;
    logic [4:0]       dbits_q;
    logic [1:0]       kind_q;

    logic             accept;
    logic [CNT_W-1:0] dummy_n;
    logic [CNT_W-1:0] data_last;

    // Fields of the setup word that the read path never looks at.
    logic unused_setup;
    assign unused_setup = ^{setup_i.rsv_hi, setup_i.wr_op, setup_i.rsv_mid};

    // Start condition and per-access phase lengths.
    always_comb begin
        accept    = (state_q == ST_IDLE) && mm_en && bus_req;
        dummy_n   = dummy_clocks(db_q, dbits_q);
        data_last = (kind_q == RD_QUAD) ? 7'd7 : 7'd31;
    end

    // Phase walker: state, bit counter, clock phase and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ph_q    <= 1'b0;
            cs_n_q  <= 1'b1;
            op_q    <= '0;
            ab_q    <= '0;
            db_q    <= '0;
            dbits_q <= '0;
            kind_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q    <= setup_i.rd_op;
                        ab_q    <= setup_i.addr_bytes;
                        db_q    <= setup_i.dum_bytes;
                        dbits_q <= setup_i.dum_bits;
                        kind_q  <= setup_i.rd_kind;
                        cnt_q   <= send_clocks(setup_i.addr_bytes) - 7'd1;
                        cs_n_q  <= 1'b0;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND, ST_DUMMY, ST_DATA: begin
                    ph_q <= ~ph_q;
                    if (ph_q) begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - 7'd1;
                        end else if (state_q == ST_SEND && dummy_n != '0) begin
                            cnt_q   <= dummy_n - 7'd1;
                            state_q <= ST_DUMMY;
                        end else if (state_q != ST_DATA) begin
                            cnt_q   <= data_last;
                            state_q <= ST_DATA;
                        end else begin
                            cs_n_q  <= 1'b1;
                            state_q <= ST_ACK;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes and pins for the shifter, the capture unit and the flash.
    always_comb begin
        load_o  = accept;
        shift_o = (state_q == ST_SEND) && ph_q;
        cap_o   = (state_q == ST_DATA) && ph_q;
        ready_o = (state_q == ST_ACK);
        cs_n_o  = cs_n_q;
        sclk_o  = ph_q;
        op_o    = accept ? setup_i.rd_op : op_q;
        ab_o    = accept ? setup_i.addr_bytes : ab_q;
        quad_o  = (kind_q == RD_QUAD);
    end

    // R10: serial clock idles low while deselected.
    p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    // R7: completion strobe lasts one cycle.
    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);
    // R7: the flash is already deselected when the word is returned.
    p_ready_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> cs_n_o);
    // R8: chip select stays high for at least a full serial clock period.
    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> cs_n_o);
    // R2: with the mode disabled an idle port is never selected.
    p_off_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o && !mm_en) |=> cs_n_o);

endmodule

// File: rtl/fls_tx_shift.sv
// Command shifter: loads opcode plus the selected low address bytes,
// left-aligned behind the opcode, and shifts them out MSB first.
// Assumes load and shift never coincide; shifts in zeros so dummy clocks send 0.
module fls_tx_shift #(
    parameter int OP_W = 8,
    parameter int AD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            shift_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [1:0]      ab_i,
    input  logic [AD_W-1:0] off_i,
    output logic            mosi_o
);

    localparam int SR_W = OP_W + AD_W;

    logic [SR_W-1:0] sr_q;
    logic [AD_W-1:0] addr_al;

    // Push the used address bytes to the top of the address slot.
    always_comb begin
        case (ab_i)
            2'd0:    addr_al = off_i << (AD_W - 8);
            2'd1:    addr_al = off_i << (AD_W - 16);
            2'd2:    addr_al = off_i << (AD_W - 24);
            default: addr_al = off_i;
        endcase
    end

    // Shift register: load on accept, advance once per serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= {op_i, addr_al};
        end else if (shift_i) begin
            sr_q <= {sr_q[SR_W-2:0], 1'b0};
        end
    end

    assign mosi_o = sr_q[SR_W-1];

    // R3: a new sequence is never loaded while one is shifting.
    p_load_shift_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));

endmodule

// File: rtl/fls_rx_capture.sv
// Data capture: assembles the returned word MSB first, one bit per serial
// clock on line 1, or one nibble per clock on lines 3..0 in quad mode.
// Assumes the width is a multiple of four.
module fls_rx_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic          quad_i,
    input  logic [3:0]    io_i,
    output logic [DW-1:0] word_o
);

    logic [DW-1:0] word_q;

    // Shift the sampled lines into the word on each rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cap_i) begin
            if (quad_i) begin
                word_q <= {word_q[DW-5:0], io_i};
            end else begin
                word_q <= {word_q[DW-2:0], io_i[1]};
            end
        end
    end

    assign word_o = word_q;

    // R6: at most one capture per serial clock.
    p_one_cap_per_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> !cap_i);

endmodule

// File: rtl/flash_mmap_reader.sv
// Top: turns window reads into serial flash read sequences.
// Assumes a 32-bit address offset and a 32-bit data word; the window starts at WIN_BASE.
module flash_mmap_reader
    import fls_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] WIN_BASE = 32'h0800_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mm_en,
    input  logic [31:0]   setup,
    input  logic          bus_req,
    input  logic [AW-1:0] bus_addr,
    output logic          bus_ready,
    output logic [31:0]   bus_rdata,
    output logic          fl_cs_n,
    output logic          fl_sclk,
    output logic          fl_mosi,
    input  logic [3:0]    fl_io_in
);

    localparam int DW = 32;

    logic [7:0]    op;
    logic [1:0]    ab;
    logic          quad;
    logic          load;
    logic          shift;
    logic          cap;
    logic [AW-1:0] offset;

    // Window-relative address for the flash.
    assign offset = bus_addr - WIN_BASE;

    fls_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mm_en   (mm_en),
        .bus_req (bus_req),
        .setup_i (setup_t'(setup)),
        .op_o    (op),
        .ab_o    (ab),
        .quad_o  (quad),
        .load_o  (load),
        .shift_o (shift),
        .cap_o   (cap),
        .cs_n_o  (fl_cs_n),
        .sclk_o  (fl_sclk),
        .ready_o (bus_ready)
    );

    fls_tx_shift #(.OP_W(8), .AD_W(AW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .op_i    (op),
        .ab_i    (ab),
        .off_i   (offset),
        .mosi_o  (fl_mosi)
    );

    fls_rx_capture #(.DW(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .quad_i  (quad),
        .io_i    (fl_io_in),
        .word_o  (bus_rdata)
    );

endmodule

// File: tb/test_flash_mmap_reader.sv
// Scoreboard bench: a driver task queues the expected sequence and word;
// one negedge process models the flash, observes the pins and compares.
module test_flash_mmap_reader;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mm_en = 1'b0;
    logic [31:0] setup = '0;
    logic        bus_req = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        fl_cs_n;
    logic        fl_sclk;
    logic        fl_mosi;
    logic [3:0]  fl_io_in = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_mmap_reader #(.AW(32), .WIN_BASE(BASE)) i_flash_mmap_reader (
        .clk(clk), .rst_n(rst_n), .mm_en(mm_en), .setup(setup),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .fl_cs_n(fl_cs_n), .fl_sclk(fl_sclk),
        .fl_mosi(fl_mosi), .fl_io_in(fl_io_in)
    );

    typedef struct {
        logic [31:0] word;
        logic [39:0] hdr;
        int          hl;
        int          pre;
        int          dcl;
        bit          quad;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] flash_word(input logic [31:0] off);
        return {off[15:0] ^ 16'hC35A, off[15:0] + 16'h1E07};
    endfunction

    // Expected sequence per R3..R6 from the setup layout.
    function automatic exp_t make_exp(input logic [31:0] off, input logic [31:0] s, input string tag);
        exp_t e;
        int nb;
        nb     = int'(s[9:8]) + 1;
        e.hl   = 8 + 8 * nb;
        e.hdr  = (40'(s[7:0]) << (8 * nb)) | (40'(off) & ((40'd1 << (8 * nb)) - 40'd1));
        e.pre  = e.hl + 8 * int'(s[11:10]) + int'(s[28:24]);
        e.quad = (s[13:12] == 2'd3);
        e.dcl  = e.quad ? 8 : 32;
        e.word = flash_word(off);
        e.tag  = tag;
        return e;
    endfunction

    // Driver: queue expectation, hold the request until ready, optionally
    // rewrite setup mid-access (R9).
    task automatic do_read(input logic [31:0] addr, input logic [31:0] s, input string tag,
                           input int chg_after, input logic [31:0] s2);
        int k;
        q.push_back(make_exp(addr - BASE, s, tag));
        @(negedge clk);
        setup    = s;
        bus_addr = addr;
        bus_req  = 1'b1;
        k = 0;
        while (1) begin
            @(negedge clk);
            k++;
            if (chg_after > 0 && k == chg_after) setup = s2;
            if (bus_ready) break;
        end
        bus_req = 1'b0;
    endtask

    // Flash model and monitor.
    int          rises = 0;
    bit          prev_sclk = 0;
    logic [39:0] hdr_obs = '0;
    int          dum_ones = 0;
    int          hi_run = 0;
    int          sclk_bad = 0;

    always @(negedge clk) begin
        if (rst_n && fl_cs_n && fl_sclk) sclk_bad++;
        if (rst_n && bus_ready) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7", "unexpected ready", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(bus_rdata == e.word, "R6", {e.tag, " data word"}, 64'(bus_rdata), 64'(e.word));
                chk(hdr_obs == e.hdr, "R3/R4", {e.tag, " opcode+address"}, 64'(hdr_obs), 64'(e.hdr));
                chk(rises == e.pre + e.dcl, "R5 R7", {e.tag, " serial clocks before ready"},
                    64'(rises), 64'(e.pre + e.dcl));
                chk(dum_ones == 0, "R5", {e.tag, " mosi high in dummy"}, 64'(dum_ones), 64'd0);
            end
        end
        if (fl_cs_n) begin
            rises = 0; prev_sclk = 0; hdr_obs = '0; dum_ones = 0; fl_io_in = '0;
            hi_run++;
        end else begin
            if (hi_run > 0) begin
                chk(hi_run >= 2, "R8", "deselect gap cycles", 64'(hi_run), 64'd2);
                hi_run = 0;
            end
            if (q.size() > 0) begin
                if (fl_sclk && !prev_sclk) begin
                    if (rises < q[0].hl) hdr_obs = {hdr_obs[38:0], fl_mosi};
                    else if (rises < q[0].pre && fl_mosi) dum_ones++;
                    rises++;
                end
                if (!fl_sclk) begin
                    int j;
                    j = rises - q[0].pre;
                    if (j >= 0 && j < q[0].dcl) begin
                        if (q[0].quad) fl_io_in = 4'((q[0].word >> (28 - 4 * j)) & 32'hF);
                        else           fl_io_in = {2'b00, q[0].word[31 - j], 1'b0};
                    end else begin
                        fl_io_in = '0;
                    end
                end
            end
            prev_sclk = fl_sclk;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int bad;
        repeat (4) @(negedge clk);
        // R1: pins during reset
        chk(fl_cs_n == 1'b1, "R1", "cs_n in reset", 64'(fl_cs_n), 64'd1);
        chk(bus_ready == 1'b0, "R1", "ready in reset", 64'(bus_ready), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(fl_cs_n == 1'b1 && fl_sclk == 1'b0, "R1", "cs_n/sclk after reset",
            64'({fl_cs_n, fl_sclk}), 64'b10);
        chk(bus_ready == 1'b0, "R1", "ready after reset", 64'(bus_ready), 64'd0);

        // R2: mode disabled, request pending
        setup = 32'h0002_0203; bus_addr = BASE + 32'h40; bus_req = 1'b1;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!fl_cs_n || bus_ready) bad++;
        end
        chk(bad == 0, "R2", "activity while disabled", 64'(bad), 64'd0);
        bus_req = 1'b0;
        @(negedge clk);
        chk(fl_cs_n == 1'b1, "R2", "cs_n after disabled request", 64'(fl_cs_n), 64'd1);
        mm_en = 1'b1;

        do_read(BASE + 32'h0001_2344, 32'h0002_0203, "R3 R4 normal single", 0, 0);
        do_read(BASE + 32'h00AB_CDE0, 32'h0002_060B, "R5 fast 8 dummy", 0, 0);
        do_read(BASE + 32'h0034_5678, 32'h0002_366B, "R6 quad", 0, 0);
        do_read(BASE + 32'h0765_4321, 32'h05AA_0313, "R4 R9 4-byte addr, 5 dummy bits", 0, 0);
        do_read(BASE + 32'h0000_009C, 32'h0300_386B, "R4 R6 1-byte addr quad", 0, 0);
        do_read(BASE + 32'h0010_2030, 32'h0002_060B, "R9 setup changed mid-access", 6, 32'h1F01_3F6B);
        // back-to-back pair for the R8 minimum gap
        do_read(BASE + 32'h0000_1000, 32'h0002_0203, "R8 back-to-back 1", 0, 0);
        do_read(BASE + 32'h0000_1004, 32'h0002_366B, "R8 back-to-back 2", 0, 0);

        repeat (6) @(negedge clk);
        chk(q.size() == 0, "R7", "unanswered reads", 64'(q.size()), 64'd0);
        chk(sclk_bad == 0, "R10", "sclk high while deselected", 64'(sclk_bad), 64'd0);
        chk(fl_cs_n == 1'b1 && bus_ready == 1'b0, "R7", "idle after last read",
            64'({fl_cs_n, bus_ready}), 64'b10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule